// File: doc/BRIEF.md
# Multiplexed-Bus Register Slave Port

This block is the slave side of a 16-bit asynchronous bus on which address and data take turns on the same lines. A bus master opens a cycle by raising the frame signal with an address on the shared lines. The block latches that address and checks it against a small window of word registers. It then answers one data phase with a four-phase acknowledge. For a read, it fetches the selected register from a local command and status block and drives it onto the bus. For a write, it hands the word or a single byte to that local block through a one-cycle strobe with byte-lane enables.

All bus inputs are asynchronous to the local clock. They pass through a multi-flop synchronizer, and the handshake is run as a state machine in the local clock domain. The write-qualifier line carries two meanings. While the address is on the bus, it marks the cycle as a write. During the write data phase, it asks for a single-byte transfer. Registers in the top 4K words of the address space also need the high-bank select line. A read request that arrives outside any framed cycle is an interrupt acknowledge, and this port does not answer it. A clear input abandons any cycle in progress.

Top module: `mux_bus_slave`

## Requirements
- R1: The address is latched from `bus_ad_i` only on a rising edge of `bus_frame_i`. A cycle ends when the frame is negated. A cycle abandoned by the clear input is not restarted until the frame falls and rises again.
- R2: The port responds only to byte addresses `BASE` to `BASE+2*NREG-1`. The register index is address bits [IDXW:1]. Any other address gives no acknowledge and no strobe.
- R3: When `BASE` lies at or above `BANK_LO` (the top 4K-word bank), an address matches only if `bus_hibank_i` is high during the address phase.
- R4: `bus_wrbyte_i` high during the address phase makes the cycle a write, and low makes it a read. A write request in a read cycle is ignored, and so is a read request in a write cycle.
- R5: On a read request in a selected read cycle, `reg_rd_o` pulses on the 3rd clock edge. On the 4th edge, `bus_ack_o` and `bus_ad_oe_o` rise with the register word on `bus_ad_o`.
- R6: On a write request in a selected write cycle, `bus_ack_o` and `reg_wr_o` rise on the 3rd clock edge. `reg_wr_data_o` carries the bus word.
- R7: `reg_wr_be_o` is 2'b11 for a word write. When `bus_wrbyte_i` is high during the write request, it is 2'b01 if address bit 0 is 0 (low byte, data on bits 7:0) and 2'b10 if address bit 0 is 1 (high byte, data on bits 15:8).
- R8: `bus_ack_o` stays high while the master holds its request. It falls, and on a read `bus_ad_oe_o` falls with it, on the 3rd clock edge after the request is negated.
- R9: A read request while the frame is low (interrupt acknowledge) gives no acknowledge and no read strobe.
- R10: `bus_clear_i` held high drops `bus_ack_o`, `bus_ad_oe_o` and both strobes by the 3rd clock edge.
- R11: `reg_rd_o` and `reg_wr_o` are single-cycle pulses, at most one per framed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clear_i | input | 1 | Bus-wide clear, asynchronous |
| bus_frame_i | input | 1 | Cycle frame; address valid at its rise |
| bus_rd_req_i | input | 1 | Master read data request |
| bus_wr_req_i | input | 1 | Master write data request |
| bus_wrbyte_i | input | 1 | Write marker (address phase) / byte marker (write phase) |
| bus_hibank_i | input | 1 | High-bank select accompanying the address |
| bus_ad_i | input | 16 | Shared address/data lines, inbound |
| bus_ad_o | output | 16 | Read data toward the bus |
| bus_ad_oe_o | output | 1 | Enable for driving `bus_ad_o` |
| bus_ack_o | output | 1 | Slave acknowledge |
| reg_idx_o | output | IDXW (2) | Selected register index |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rd_data_i | input | 16 | Register word returned by the local block |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wr_data_o | output | 16 | Write word |
| reg_wr_be_o | output | 2 | Byte-lane enables (bit 0 low byte) |

## Verification
Every bus input passes two synchronizer flops before the state machine acts on it. A write acknowledge and write strobe therefore appear on the 3rd clock edge after the request changes. A read acknowledge appears on the 4th edge, one edge after the read strobe, and an acknowledge release appears on the 3rd edge. The bench changes inputs on falling edges. After each change it counts rising edges and samples on the next falling edge, so each check compares the exact edge number against 3 or 4. Cases that must be ignored are watched for twelve cycles through acknowledge and strobe counters, and the register contents are read back over the bus against a model in the bench.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAMED,
    ST_RD_WAIT,
    ST_RD_ACK,
    ST_WR_ACK,
    ST_DONE
  } mbs_state_e;

  localparam logic [1:0] BE_WORD = 2'b11;
  localparam logic [1:0] BE_LOW  = 2'b01;
  localparam logic [1:0] BE_HIGH = 2'b10;

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/mbs_decode.sv
module mbs_decode #(
  parameter int          AW      = 16,
  parameter int          NREG    = 4,
  parameter int          IDXW    = 2,
  parameter logic [15:0] BASE    = 16'hFF40,
  parameter logic [15:0] BANK_LO = 16'hE000
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            hibank_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);

  localparam bit IN_BANK = (BASE >= BANK_LO);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  logic window_hit;
  logic bank_ok;

  assign window_hit = (addr_i[AW-1:IDXW+1] == BASE_A[AW-1:IDXW+1]);

  if (IN_BANK) begin : g_bank_needed
    assign bank_ok = hibank_i;
  end else begin : g_bank_free
    assign bank_ok = 1'b1;
  end

  always_comb begin
    idx_o = addr_i[IDXW:1];
    hit_o = window_hit && bank_ok && (int'(addr_i[IDXW:1]) < NREG);
  end

endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            frame_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            wrbyte_i,
  input  logic [DW-1:0]   ad_i,
  input  logic            dec_hit_i,
  input  logic [IDXW-1:0] dec_idx_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            ack_o,
  output logic [IDXW-1:0] idx_o,
  output logic            rd_stb_o,
  output logic            wr_stb_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [1:0]      wr_be_o
);

  mbs_state_e state_q;
  logic       frame_q;
  logic       hit_q;
  logic       is_wr_q;
  logic       lane_q;
  logic       frame_rise;

  assign frame_rise = frame_i && !frame_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_q   <= ST_IDLE;
      frame_q   <= 1'b1;
      hit_q     <= 1'b0;
      is_wr_q   <= 1'b0;
      lane_q    <= 1'b0;
      idx_o     <= '0;
      ad_o      <= '0;
      ad_oe_o   <= 1'b0;
      ack_o     <= 1'b0;
      rd_stb_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      wr_be_o   <= '0;
    end else begin
      frame_q  <= frame_i;
      rd_stb_o <= 1'b0;
      wr_stb_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (frame_rise) begin
            hit_q   <= dec_hit_i;
            idx_o   <= dec_idx_i;
            lane_q  <= ad_i[0];
            is_wr_q <= wrbyte_i;
            state_q <= ST_FRAMED;
          end
        end
        ST_FRAMED: begin
          if (!frame_i) begin
            state_q <= ST_IDLE;
          end else if (hit_q && !is_wr_q && rd_i) begin
            rd_stb_o <= 1'b1;
            state_q  <= ST_RD_WAIT;
          end else if (hit_q && is_wr_q && wr_i) begin
            wr_stb_o  <= 1'b1;
            wr_data_o <= ad_i;
            wr_be_o   <= !wrbyte_i ? BE_WORD : (lane_q ? BE_HIGH : BE_LOW);
            ack_o     <= 1'b1;
            state_q   <= ST_WR_ACK;
          end
        end
        ST_RD_WAIT: begin
          ad_o    <= rd_data_i;
          ad_oe_o <= 1'b1;
          ack_o   <= 1'b1;
          state_q <= ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (!rd_i) begin
            ack_o   <= 1'b0;
            ad_oe_o <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_WR_ACK: begin
          if (!wr_i) begin
            ack_o   <= 1'b0;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (!frame_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int          DW      = 16,
  parameter int          NREG    = 4,
  parameter int          IDXW    = (NREG > 1) ? $clog2(NREG) : 1,
  parameter int          STAGES  = 2,
  parameter logic [15:0] BASE    = 16'hFF40,
  parameter logic [15:0] BANK_LO = 16'hE000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_clear_i,
  input  logic            bus_frame_i,
  input  logic            bus_rd_req_i,
  input  logic            bus_wr_req_i,
  input  logic            bus_wrbyte_i,
  input  logic            bus_hibank_i,
  input  logic [DW-1:0]   bus_ad_i,
  output logic [DW-1:0]   bus_ad_o,
  output logic            bus_ad_oe_o,
  output logic            bus_ack_o,
  output logic [IDXW-1:0] reg_idx_o,
  output logic            reg_rd_o,
  input  logic [DW-1:0]   reg_rd_data_i,
  output logic            reg_wr_o,
  output logic [DW-1:0]   reg_wr_data_o,
  output logic [1:0]      reg_wr_be_o
);

  localparam int CTLW = 6;
  localparam int SW   = CTLW + DW;

  logic [SW-1:0]   raw_in;
  logic [SW-1:0]   syn_in;
  logic            clr_s, frame_s, rd_s, wr_s, wrbyte_s, hibank_s;
  logic [DW-1:0]   ad_s;
  logic            dec_hit;
  logic [IDXW-1:0] dec_idx;

  assign raw_in = {bus_clear_i, bus_frame_i, bus_rd_req_i, bus_wr_req_i,
                   bus_wrbyte_i, bus_hibank_i, bus_ad_i};

  mbs_sync #(.W(SW), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  assign {clr_s, frame_s, rd_s, wr_s, wrbyte_s, hibank_s, ad_s} = syn_in;

  mbs_decode #(
    .AW(DW), .NREG(NREG), .IDXW(IDXW), .BASE(BASE), .BANK_LO(BANK_LO)
  ) u_decode (
    .addr_i   (ad_s),
    .hibank_i (hibank_s),
    .hit_o    (dec_hit),
    .idx_o    (dec_idx)
  );

  mbs_fsm #(.DW(DW), .IDXW(IDXW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_s),
    .frame_i   (frame_s),
    .rd_i      (rd_s),
    .wr_i      (wr_s),
    .wrbyte_i  (wrbyte_s),
    .ad_i      (ad_s),
    .dec_hit_i (dec_hit),
    .dec_idx_i (dec_idx),
    .rd_data_i (reg_rd_data_i),
    .ad_o      (bus_ad_o),
    .ad_oe_o   (bus_ad_oe_o),
    .ack_o     (bus_ack_o),
    .idx_o     (reg_idx_o),
    .rd_stb_o  (reg_rd_o),
    .wr_stb_o  (reg_wr_o),
    .wr_data_o (reg_wr_data_o),
    .wr_be_o   (reg_wr_be_o)
  );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic       clk,
  input logic       rst,
  input logic       clr_s,
  input logic       bus_clear_i,
  input logic       bus_frame_i,
  input logic       bus_rd_req_i,
  input logic       bus_wr_req_i,
  input logic       bus_ad_oe_o,
  input logic       bus_ack_o,
  input logic       reg_rd_o,
  input logic       reg_wr_o,
  input logic [1:0] reg_wr_be_o
);

  // R11: strobes last one cycle
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_rd_o |=> !reg_rd_o);
  p_wr_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> !reg_wr_o);

  // R5: read strobe is followed by acknowledge with data driven
  p_rd_then_ack_r5: assert property (@(posedge clk) disable iff (rst || clr_s)
    reg_rd_o |=> (bus_ack_o && bus_ad_oe_o));

  // R5: data lines only driven while acknowledging
  p_drive_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe_o |-> bus_ack_o);

  // R7: a write always enables at least one lane
  p_be_valid_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |-> ($countones(reg_wr_be_o) >= 1));

  // R1: an acknowledge only starts inside a framed cycle
  p_ack_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_o) |-> $past(bus_frame_i, 3));

  // R8: acknowledge is held until the request is withdrawn (or cleared)
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_o) |-> ((!$past(bus_rd_req_i, 3) && !$past(bus_wr_req_i, 3))
                          || $past(clr_s) || $past(rst)));

  // R10: a held clear forces the acknowledge low
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_clear_i, 1) && $past(bus_clear_i, 2) && $past(bus_clear_i, 3))
      |-> (!bus_ack_o && !bus_ad_oe_o));

endmodule

bind mux_bus_slave mbs_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .clr_s        (clr_s),
  .bus_clear_i  (bus_clear_i),
  .bus_frame_i  (bus_frame_i),
  .bus_rd_req_i (bus_rd_req_i),
  .bus_wr_req_i (bus_wr_req_i),
  .bus_ad_oe_o  (bus_ad_oe_o),
  .bus_ack_o    (bus_ack_o),
  .reg_rd_o     (reg_rd_o),
  .reg_wr_o     (reg_wr_o),
  .reg_wr_be_o  (reg_wr_be_o)
);

// File: tb/mux_bus_slave_tb_top.sv
`timescale 1ns/1ps
module mux_bus_slave_tb_top;

  localparam logic [15:0] BASE = 16'hFF40;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_clear_i = 1'b0;
  logic        bus_frame_i = 1'b0;
  logic        bus_rd_req_i = 1'b0;
  logic        bus_wr_req_i = 1'b0;
  logic        bus_wrbyte_i = 1'b0;
  logic        bus_hibank_i = 1'b0;
  logic [15:0] bus_ad_i = '0;
  logic [15:0] bus_ad_o;
  logic        bus_ad_oe_o;
  logic        bus_ack_o;
  logic [1:0]  reg_idx_o;
  logic        reg_rd_o;
  logic [15:0] reg_rd_data_i;
  logic        reg_wr_o;
  logic [15:0] reg_wr_data_o;
  logic [1:0]  reg_wr_be_o;

  int nchk = 0;
  int nerr = 0;
  int cnt_ack = 0;
  int cnt_rd = 0;
  int cnt_wr = 0;
  logic [15:0] loc_regs [NREG];
  logic [15:0] expv [NREG];

  always #10 clk = ~clk;

  mux_bus_slave dut_i (
    .clk(clk), .rst(rst), .bus_clear_i(bus_clear_i), .bus_frame_i(bus_frame_i),
    .bus_rd_req_i(bus_rd_req_i), .bus_wr_req_i(bus_wr_req_i),
    .bus_wrbyte_i(bus_wrbyte_i), .bus_hibank_i(bus_hibank_i),
    .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o),
    .bus_ack_o(bus_ack_o), .reg_idx_o(reg_idx_o), .reg_rd_o(reg_rd_o),
    .reg_rd_data_i(reg_rd_data_i), .reg_wr_o(reg_wr_o),
    .reg_wr_data_o(reg_wr_data_o), .reg_wr_be_o(reg_wr_be_o)
  );

  // local register block
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) loc_regs[i] <= '0;
    end else if (reg_wr_o) begin
      if (reg_wr_be_o[0]) loc_regs[reg_idx_o][7:0]  <= reg_wr_data_o[7:0];
      if (reg_wr_be_o[1]) loc_regs[reg_idx_o][15:8] <= reg_wr_data_o[15:8];
    end
  end
  assign reg_rd_data_i = loc_regs[reg_idx_o];

  always @(negedge clk) begin
    if (bus_ack_o) cnt_ack++;
    if (reg_rd_o)  cnt_rd++;
    if (reg_wr_o)  cnt_wr++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic open_cycle(input logic [15:0] addr, input logic hib, input logic wrc);
    @(negedge clk);
    bus_ad_i = addr; bus_hibank_i = hib; bus_wrbyte_i = wrc; bus_frame_i = 1'b1;
    repeat (4) @(negedge clk);
    bus_ad_i = '0; bus_hibank_i = 1'b0; bus_wrbyte_i = 1'b0;
  endtask

  task automatic close_cycle();
    @(negedge clk);
    bus_frame_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ack(input logic level, output int n);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      if (bus_ack_o == level) break;
    end
  endtask

  task automatic do_write(input int idx, input logic lane, input logic bytem,
                          input logic [15:0] data, input string req);
    int n;
    logic [1:0] be;
    be = !bytem ? 2'b11 : (lane ? 2'b10 : 2'b01);
    open_cycle(BASE + 16'(2*idx) + 16'(lane), 1'b1, 1'b1);
    @(negedge clk);
    bus_ad_i = data; bus_wrbyte_i = bytem; bus_wr_req_i = 1'b1;
    wait_ack(1'b1, n);
    chk(n == 3, "R6", "write ack edge", n, 3);
    chk(reg_wr_o == 1'b1, "R6", "write strobe with ack", reg_wr_o, 1);
    chk(reg_idx_o == 2'(idx), "R2", "write index", reg_idx_o, idx);
    chk(reg_wr_data_o == data, "R6", "write data", reg_wr_data_o, data);
    chk(reg_wr_be_o == be, req, "byte enables", reg_wr_be_o, be);
    repeat (5) @(negedge clk);
    chk(bus_ack_o == 1'b1, "R8", "ack held during write", bus_ack_o, 1);
    bus_wr_req_i = 1'b0; bus_wrbyte_i = 1'b0; bus_ad_i = '0;
    wait_ack(1'b0, n);
    chk(n == 3, "R8", "write ack release edge", n, 3);
    close_cycle();
    if (be[0]) expv[idx][7:0]  = data[7:0];
    if (be[1]) expv[idx][15:8] = data[15:8];
  endtask

  task automatic do_read(input int idx, input string req);
    int n;
    int rd0;
    open_cycle(BASE + 16'(2*idx), 1'b1, 1'b0);
    rd0 = cnt_rd;
    @(negedge clk);
    bus_rd_req_i = 1'b1;
    wait_ack(1'b1, n);
    chk(n == 4, "R5", "read ack edge", n, 4);
    chk(cnt_rd - rd0 == 1, "R11", "one read strobe", cnt_rd - rd0, 1);
    chk(bus_ad_oe_o == 1'b1, "R5", "drive enable", bus_ad_oe_o, 1);
    chk(bus_ad_o == expv[idx], req, "read data", bus_ad_o, expv[idx]);
    repeat (5) @(negedge clk);
    chk(bus_ack_o && bus_ad_oe_o, "R8", "ack held during read", bus_ack_o, 1);
    bus_rd_req_i = 1'b0;
    wait_ack(1'b0, n);
    chk(n == 3, "R8", "read ack release edge", n, 3);
    chk(bus_ad_oe_o == 1'b0, "R8", "drive released", bus_ad_oe_o, 0);
    close_cycle();
  endtask

  // cycle that must get no answer; req_kind 0 = read request, 1 = write request
  task automatic do_ignored(input logic [15:0] addr, input logic hib, input logic wrc,
                            input logic req_kind, input string req, input string what);
    int a0, r0, w0;
    open_cycle(addr, hib, wrc);
    a0 = cnt_ack; r0 = cnt_rd; w0 = cnt_wr;
    @(negedge clk);
    bus_ad_i = 16'h5A5A;
    if (req_kind) bus_wr_req_i = 1'b1; else bus_rd_req_i = 1'b1;
    repeat (12) @(negedge clk);
    chk((cnt_ack == a0) && (cnt_rd == r0) && (cnt_wr == w0), req, what,
        cnt_ack - a0 + cnt_rd - r0 + cnt_wr - w0, 0);
    bus_wr_req_i = 1'b0; bus_rd_req_i = 1'b0; bus_ad_i = '0;
    close_cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int n, a0, r0;
    for (int i = 0; i < NREG; i++) expv[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_ack_o && !bus_ad_oe_o && !reg_rd_o && !reg_wr_o, "R10", "reset state",
        {bus_ack_o, bus_ad_oe_o, reg_rd_o, reg_wr_o}, 0);

    // R6 word writes then R5 read-back across the window
    for (int i = 0; i < NREG; i++)
      do_write(i, 1'b0, 1'b0, 16'h1357 + 16'(i) * 16'h2222, "R7");
    for (int i = 0; i < NREG; i++) do_read(i, "R5");
    for (int i = 0; i < NREG; i++)
      do_write(i, 1'b0, 1'b0, ~(16'h0F0F << i), "R7");
    for (int i = 0; i < NREG; i++) do_read(i, "R5");

    // R7 byte lanes, both address parities
    for (int i = 0; i < NREG; i++) begin
      do_write(i, 1'b0, 1'b1, {8'hC0 + 8'(i), 8'h30 + 8'(i)}, "R7");
      do_write(i, 1'b1, 1'b1, {8'hE8 + 8'(i), 8'h71 + 8'(i)}, "R7");
    end
    for (int i = 0; i < NREG; i++) do_read(i, "R7");

    // R2 outside the window, R3 missing bank select
    do_ignored(BASE - 16'd2, 1'b1, 1'b1, 1'b1, "R2", "below window ignored");
    do_ignored(BASE + 16'(2*NREG), 1'b1, 1'b0, 1'b0, "R2", "above window ignored");
    do_ignored(BASE, 1'b0, 1'b1, 1'b1, "R3", "write without bank select");
    do_ignored(BASE + 16'd2, 1'b0, 1'b0, 1'b0, "R3", "read without bank select");
    // R4 wrong-direction requests
    do_ignored(BASE, 1'b1, 1'b0, 1'b1, "R4", "write request in read cycle");
    do_ignored(BASE + 16'd4, 1'b1, 1'b1, 1'b0, "R4", "read request in write cycle");
    for (int i = 0; i < NREG; i++) do_read(i, "R4");

    // R9 read request without frame
    a0 = cnt_ack; r0 = cnt_rd;
    @(negedge clk);
    bus_ad_i = BASE; bus_rd_req_i = 1'b1;
    repeat (12) @(negedge clk);
    chk((cnt_ack == a0) && (cnt_rd == r0), "R9", "unframed read ignored",
        cnt_ack - a0 + cnt_rd - r0, 0);
    bus_rd_req_i = 1'b0; bus_ad_i = '0;
    repeat (4) @(negedge clk);

    // R10 clear mid-cycle, R1 no restart without a new frame
    open_cycle(BASE + 16'd6, 1'b1, 1'b1);
    @(negedge clk);
    bus_ad_i = 16'hBEEF; bus_wr_req_i = 1'b1;
    wait_ack(1'b1, n);
    chk(bus_ack_o == 1'b1, "R6", "ack before clear", bus_ack_o, 1);
    expv[3] = 16'hBEEF;
    bus_clear_i = 1'b1;
    wait_ack(1'b0, n);
    chk(n == 3, "R10", "clear drops ack edge", n, 3);
    repeat (3) @(negedge clk);
    bus_clear_i = 1'b0; bus_wr_req_i = 1'b0; bus_ad_i = '0;
    repeat (5) @(negedge clk);
    a0 = cnt_ack; r0 = cnt_rd;
    bus_rd_req_i = 1'b1;
    repeat (12) @(negedge clk);
    chk((cnt_ack == a0) && (cnt_rd == r0), "R1", "no answer without new frame",
        cnt_ack - a0 + cnt_rd - r0, 0);
    bus_rd_req_i = 1'b0;
    close_cycle();
    do_read(3, "R1");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule